// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Forwarding

This block gathers thirty-two level-sensitive interrupt sources behind one primary controller. Each clock it copies the source levels into a raw register, ANDs them with a programmable enable mask, and raises one summary line whenever any enabled source is active. That summary line is the top bit of a 32-bit output vector, and the vector feeds the matching inputs of the primary controller.

Some sources are urgent enough to skip the summary stage. Sources 21 to 30 can each be forwarded one-to-one to the same-numbered line of the output vector. Each forwarded line has its own forward-enable bit. Output lines that are not forwarded, and lines outside that window, stay low.

Software controls the block through a single-cycle register strobe. The enable mask and the forward-enable register are both changed through separate set and clear registers, so no read-modify-write is needed. A software-interrupt alias gives direct control of enable bit 0.

Top module: `irq_sec_ctrl`

## Requirements
- R1: After reset, the enable mask and the forward-enable register read 0, and every bit of `parent_o` is low.
- R2: The raw register samples `src_i` on every clock edge, with no edge latching. Reading word index 1 returns it, so a bit clears again once its source falls.
- R3: Reading word index 0 returns raw AND enable. Reading word index 2 returns the enable mask.
- R4: Writing word index 2 ORs the written data into the enable mask. Writing word index 3 clears every enable bit that is written as 1.
- R5: Writing word index 4 with any nonzero value sets enable bit 0, and writing word index 5 with any nonzero value clears it. A zero value at either index changes nothing. Reading word index 4 returns raw bit 0 in bit 0 and zeros above it.
- R6: Writing word index 8 ORs the written data, masked with 0x7FE00000, into the forward-enable register, so only bits 21 to 30 can ever be set. Reading word index 8 returns the forward-enable register.
- R7: Writing word index 9 clears every forward-enable bit that is written as 1.
- R8: `parent_o[31]` is high exactly when raw AND enable was nonzero in the previous cycle.
- R9: For each i from 21 to 30, `parent_o[i]` equals raw[i] AND forward-enable[i] from the previous cycle. `parent_o[20:0]` is always 0.
- R10: Reads of unmapped word indexes return 0. Writes to unmapped indexes, and to the read-only indexes 0 and 1, leave every register and output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_addr_i | input | 12 | Byte offset; the word index is bits 11:2 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| parent_o | output | 32 | Lines to the primary controller: bit 31 is the summary, bits 30:21 are forwarded sources |

## Verification
A source level change and a register write can land on the same clock edge. Both then feed the next state of the summary and forwarded lines together.

The bench provokes this case by raising a source in the same cycle as it strobes the write that enables that source. It judges the result two ways. One cycle later, the masked status must already show the bit. One cycle after that, `parent_o[31]` must be high, with no cycle in which the write was lost or the old level was used.

Forwarding is exercised the same way, with the forward-enable register set and cleared while the sources are held.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned SIC_N = 32;
  typedef logic [SIC_N-1:0] sic_word_t;

  // word indexes decoded by the register file
  localparam int unsigned IX_MASKED   = 0;
  localparam int unsigned IX_RAW      = 1;
  localparam int unsigned IX_EN_SET   = 2;
  localparam int unsigned IX_EN_CLR   = 3;
  localparam int unsigned IX_SOFT_SET = 4;
  localparam int unsigned IX_SOFT_CLR = 5;
  localparam int unsigned IX_FW_SET   = 8;
  localparam int unsigned IX_FW_CLR   = 9;

  function automatic sic_word_t window_mask(input int unsigned lo, input int unsigned hi);
    sic_word_t m;
    m = '0;
    for (int unsigned i = 0; i < SIC_N; i++)
      if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic any_pending(input sic_word_t raw, input sic_word_t en);
    return |(raw & en);
  endfunction
endpackage

// File: rtl/sic_regfile.sv
module sic_regfile
  import sic_pkg::*;
#(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned PASS_LO = 21,
  parameter int unsigned PASS_HI = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sic_word_t        src_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  sic_word_t        wdata_i,
  output sic_word_t        rdata_o,
  output sic_word_t        raw_o,
  output sic_word_t        en_o,
  output sic_word_t        fw_o
);
  localparam sic_word_t WIN = window_mask(PASS_LO, PASS_HI);

  sic_word_t raw_q, en_q, fw_q, en_d, fw_d;

  // decoded write events, named for the assertions
  logic hit_en_set, hit_en_clr, hit_soft_set, hit_soft_clr, hit_fw_set, hit_fw_clr;
  logic ignored_wr, wdata_nz;

  assign wdata_nz     = |wdata_i;
  assign hit_en_set   = wr_i && (idx_i == IDX_W'(IX_EN_SET));
  assign hit_en_clr   = wr_i && (idx_i == IDX_W'(IX_EN_CLR));
  assign hit_soft_set = wr_i && (idx_i == IDX_W'(IX_SOFT_SET));
  assign hit_soft_clr = wr_i && (idx_i == IDX_W'(IX_SOFT_CLR));
  assign hit_fw_set   = wr_i && (idx_i == IDX_W'(IX_FW_SET));
  assign hit_fw_clr   = wr_i && (idx_i == IDX_W'(IX_FW_CLR));
  assign ignored_wr   = wr_i && !(hit_en_set || hit_en_clr || hit_soft_set ||
                                  hit_soft_clr || hit_fw_set || hit_fw_clr);

  always_comb begin
    en_d = en_q;
    if (hit_en_set) en_d = en_q | wdata_i;
    if (hit_en_clr) en_d = en_q & ~wdata_i;
    if (hit_soft_set && wdata_nz) en_d[0] = 1'b1;
    if (hit_soft_clr && wdata_nz) en_d[0] = 1'b0;
  end

  always_comb begin
    fw_d = fw_q;
    if (hit_fw_set) fw_d = fw_q | (wdata_i & WIN);
    if (hit_fw_clr) fw_d = fw_q & ~wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      fw_q  <= '0;
    end else begin
      raw_q <= src_i;
      en_q  <= en_d;
      fw_q  <= fw_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i == IDX_W'(IX_MASKED))         rdata_o = raw_q & en_q;
    else if (idx_i == IDX_W'(IX_RAW))       rdata_o = raw_q;
    else if (idx_i == IDX_W'(IX_EN_SET))    rdata_o = en_q;
    else if (idx_i == IDX_W'(IX_SOFT_SET))  rdata_o = {{(SIC_N-1){1'b0}}, raw_q[0]};
    else if (idx_i == IDX_W'(IX_FW_SET))    rdata_o = fw_q;
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign fw_o  = fw_q;

  // R6
  fw_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_q & ~WIN) == '0);
  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en_set |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  // R4
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en_clr |=> ((en_q & $past(wdata_i)) == '0));
  // R5
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_soft_set && wdata_nz) |=> en_q[0]);
  // R7
  fw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fw_clr |=> ((fw_q & $past(wdata_i)) == '0));
  // R10
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_wr |=> ($stable(en_q) && $stable(fw_q)));
endmodule

// File: rtl/sic_route.sv
module sic_route
  import sic_pkg::*;
#(
  parameter int unsigned PASS_LO = 21,
  parameter int unsigned PASS_HI = 30
) (
  input  logic      clk,
  input  logic      rst_n,
  input  sic_word_t raw_i,
  input  sic_word_t en_i,
  input  sic_word_t fw_i,
  output sic_word_t parent_o
);
  sic_word_t parent_d, parent_q;
  logic      summary_w;

  assign summary_w = any_pending(raw_i, en_i);

  for (genvar i = 0; i < SIC_N; i++) begin : g_line
    if (i == SIC_N - 1) begin : g_sum
      assign parent_d[i] = summary_w;
    end else if (i >= PASS_LO && i <= PASS_HI) begin : g_fwd
      assign parent_d[i] = raw_i[i] & fw_i[i];
    end else begin : g_off
      assign parent_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) parent_q <= '0;
    else        parent_q <= parent_d;
  end

  assign parent_o = parent_q;

  // R8
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (parent_o[SIC_N-1] == $past(|(raw_i & en_i))));
  // R9
  forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((parent_o & window_mask(PASS_LO, PASS_HI)) ==
              $past(raw_i & fw_i & window_mask(PASS_LO, PASS_HI))));
endmodule

// File: rtl/irq_sec_ctrl.sv
module irq_sec_ctrl
  import sic_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PASS_LO = 21,
  parameter int unsigned PASS_HI = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIC_N-1:0]  src_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [SIC_N-1:0]  bus_wdata_i,
  output logic [SIC_N-1:0]  bus_rdata_o,
  output logic [SIC_N-1:0]  parent_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  sic_word_t raw_w, en_w, fw_w;

  sic_regfile #(.IDX_W(IDX_W), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_i(bus_wr_i),
    .idx_i(bus_addr_i[ADDR_W-1:2]), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .raw_o(raw_w), .en_o(en_w), .fw_o(fw_w)
  );

  sic_route #(.PASS_LO(PASS_LO), .PASS_HI(PASS_HI)) u_route (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_w), .en_i(en_w), .fw_i(fw_w),
    .parent_o(parent_o)
  );

  // R9
  quiet_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parent_o[PASS_LO-1:0] == '0);
endmodule

// File: tb/irq_sec_ctrl_bench.sv
module irq_sec_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd, parent;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_sec_ctrl u_irq_sec_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wd), .bus_rdata_o(rd), .parent_o(parent)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [9:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = {idx, 2'b00}; wd = d;
    @(negedge clk);
    wr = 1'b0; wd = '0;
  endtask

  task automatic bus_read(input logic [9:0] idx, output logic [31:0] d);
    addr = {idx, 2'b00};
    #1;
    d = rd;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 parent after reset", parent, 32'h0);
    bus_read(10'd2, v); chk("R1 enable after reset", v, 32'h0);
    bus_read(10'd8, v); chk("R1 forward after reset", v, 32'h0);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    src = 32'hA5A5_0F0F; step(1);
    bus_read(10'd1, v); chk("R2 raw follows source", v, 32'hA5A5_0F0F);
    src = 32'h0; step(1);
    bus_read(10'd1, v); chk("R2 raw clears when source falls", v, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    bus_write(10'd2, 32'h0000_00F0);
    bus_write(10'd2, 32'h0000_0F00);
    bus_read(10'd2, v); chk("R4 enable set ORs", v, 32'h0000_0FF0);
    bus_write(10'd3, 32'h0000_0030);
    bus_read(10'd2, v); chk("R4 enable clear", v, 32'h0000_0FC0);
    src = 32'h0000_0048; step(1);
    bus_read(10'd0, v); chk("R3 masked status", v, 32'h0000_0040);
    step(1); chk("R8 summary high for enabled source", parent, 32'h8000_0000);
    src = 32'h0000_0008; step(2);
    chk("R8 summary low for disabled source", parent, 32'h0);
    bus_read(10'd0, v); chk("R3 masked status empty", v, 32'h0);
    src = '0;
    bus_write(10'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    bus_write(10'd4, 32'h0);
    bus_read(10'd2, v); chk("R5 zero write to soft set ignored", v, 32'h0);
    bus_write(10'd4, 32'h0000_0500);
    bus_read(10'd2, v); chk("R5 soft set enables bit 0", v, 32'h1);
    src = 32'h8000_0001; step(1);
    bus_read(10'd4, v); chk("R5 soft read returns raw bit 0", v, 32'h1);
    step(1); chk("R8 summary from bit 0", parent, 32'h8000_0000);
    bus_write(10'd5, 32'h0);
    bus_read(10'd2, v); chk("R5 zero write to soft clear ignored", v, 32'h1);
    bus_write(10'd5, 32'h0000_0002);
    bus_read(10'd2, v); chk("R5 soft clear", v, 32'h0);
    src = '0; step(2);
  endtask

  task automatic t_forward();
    logic [31:0] v;
    bus_write(10'd8, 32'hFFFF_FFFF);
    bus_read(10'd8, v); chk("R6 only window bits settable", v, 32'h7FE0_0000);
    src = 32'hFFFF_FFFF; step(2);
    chk("R9 forwarded lines follow sources", parent, 32'h7FE0_0000);
    bus_write(10'd2, 32'hFFFF_FFFF); step(1);
    chk("R9 low lines stay low with all enabled", parent, 32'hFFE0_0000);
    bus_write(10'd3, 32'hFFFF_FFFF);
    bus_write(10'd9, 32'h7FC0_0000);
    bus_read(10'd8, v); chk("R7 forward clear", v, 32'h0020_0000);
    step(1); chk("R9 forwarding stops under clear", parent, 32'h0020_0000);
    src = 32'h0; step(2);
    chk("R9 forwarded line follows falling source", parent, 32'h0);
    bus_write(10'd9, 32'h0020_0000);
    src = 32'h0020_0000; step(2);
    chk("R9 no forward once disabled", parent, 32'h0);
    src = '0; step(2);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    @(negedge clk);
    src = 32'h0000_0020; wr = 1'b1; addr = {10'd2, 2'b00}; wd = 32'h0000_0020;
    @(negedge clk);
    wr = 1'b0; wd = '0;
    bus_read(10'd0, v); chk("R3 masked after simultaneous rise and enable", v, 32'h0000_0020);
    step(1); chk("R8 summary after simultaneous rise and enable", parent, 32'h8000_0000);
    bus_write(10'd3, 32'hFFFF_FFFF); src = '0; step(2);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_write(10'd2, 32'h0000_0100);
    bus_write(10'd8, 32'h0040_0000);
    bus_write(10'd0, 32'hFFFF_FFFF);
    bus_write(10'd1, 32'hFFFF_FFFF);
    bus_write(10'd6, 32'hFFFF_FFFF);
    bus_write(10'd1023, 32'hFFFF_FFFF);
    bus_read(10'd2, v); chk("R10 enable untouched by ignored writes", v, 32'h0000_0100);
    bus_read(10'd8, v); chk("R10 forward untouched by ignored writes", v, 32'h0040_0000);
    step(1); chk("R10 outputs untouched by ignored writes", parent, 32'h0);
    src = 32'hFFFF_FFFF; step(1);
    bus_read(10'd3, v); chk("R10 unmapped read index 3", v, 32'h0);
    bus_read(10'd7, v); chk("R10 unmapped read index 7", v, 32'h0);
    bus_read(10'd1023, v); chk("R10 unmapped read top index", v, 32'h0);
    src = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_raw();
    t_enable();
    t_soft();
    t_forward();
    t_same_cycle();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule